// File: doc/BRIEF.md
# Trace start/stop latch

This block holds a single on/off tracing state that is set and cleared by comparator match pulses. Two families of match lines come in: sixteen address-comparator matches and eight watchpoint matches. Per-line select masks decide which lines count as "start" events and which count as "stop" events. A start event turns the state on and a stop event turns it off. The state holds its value between events.

The state drives two outputs. The first is the trace-enable contribution, which is gated by an on/off control input. The second is a resource hit, which reports the state whenever the resource selector carries the code 7'b101_1111. The resource hit does not depend on the on/off control.

The select masks are written and read through a small address/data/write-enable port. The watchpoint select register exists only when the `WP_PRESENT` parameter is set. The control is a two-state machine with states OFF and ON:
- The SET transition goes from OFF to ON when a start event is seen.
- The CLEAR transition goes from ON to OFF when a stop event is seen without a start event.
- Every other cycle takes the HOLD transition and keeps the current state.

Top module: `trace_gate_latch`

## Requirements
- R1: After reset the state is OFF, `trace_en_o` and `res_hit_o` are 0, and both select registers read 0.
- R2: A write to address 0 loads the address start mask from data bits [15:0] and the address stop mask from bits [31:16]. A read of address 0 returns them in the same positions.
- R3: A pulse on a selected start line turns the state ON. The state then stays ON until a stop event.
- R4: A pulse on a selected stop line (with no start in the same cycle) turns the state OFF. The state then stays OFF until a start event.
- R5: Pulses on match lines selected in neither mask leave the state unchanged.
- R6: When a start and a stop occur in the same cycle, the stop is ignored and the state goes ON. This also covers a single line that is selected in both masks.
- R7: Address 1 holds the watchpoint start mask in bits [7:0] and the watchpoint stop mask in bits [23:16]. All other bits of address 1 read 0.
- R8: Selected watchpoint lines start and stop the state in the same way as address lines.
- R9: `trace_en_o` equals the state while `onoff_i` is 1, and is 0 while `onoff_i` is 0.
- R10: `res_hit_o` equals the state when `res_sel_i` is 7'b101_1111, whatever the value of `onoff_i`. For any other selector value it is 0.
- R11: Writes to any address other than 0 and 1 change no register. Reads of those addresses return 0.
- R12: A match pulse is captured on the rising edge on which it is present. The state changes on the next rising edge, not on the capture edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Register write enable |
| cfg_addr_i | input | 2 | Register address (write and read) |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Register read data for `cfg_addr_i` |
| addr_match_i | input | 16 | Address comparator match pulses |
| wp_match_i | input | 8 | Watchpoint match pulses |
| onoff_i | input | 1 | Lets the latch control trace enable |
| res_sel_i | input | 7 | Resource selector code |
| trace_en_o | output | 1 | Gated trace-enable contribution |
| res_hit_o | output | 1 | Latch state as a selectable resource |

## Verification
On every cycle, the assertions check the following:
- A captured start always leaves the state ON one edge later.
- A lone captured stop always leaves it OFF.
- With no captured event the state is stable.
- Reset forces OFF.
- The reserved read-data bits of the watchpoint register are zero.
- The gated output is low while the control is off.

Only the bench's scenarios can show the rest:
- The mask field positions.
- That unselected lines have no effect.
- That a line in both masks acts as a start.
- The two-edge latency.
- The resource code decoding.
- That writes to unmapped addresses change nothing.

// File: rtl/trace_gate_pkg.sv
`timescale 1ns/1ps
package trace_gate_pkg;
    localparam int unsigned REG_DATA_W  = 32;
    localparam int unsigned REG_ADDR_W  = 2;
    localparam int unsigned FIELD_STEP  = 16;
    localparam int unsigned RES_CODE_W  = 7;

    localparam logic [REG_ADDR_W-1:0] ADDR_SEL_REG = 2'd0;
    localparam logic [REG_ADDR_W-1:0] WP_SEL_REG   = 2'd1;

    localparam logic [RES_CODE_W-1:0] RES_LATCH_CODE = 7'b101_1111;

    typedef enum logic {
        ST_OFF = 1'b0,
        ST_ON  = 1'b1
    } gate_state_e;

    typedef struct packed {
        logic start;
        logic stop;
    } gate_evt_t;
endpackage

// File: rtl/tgl_cfg_regs.sv
`timescale 1ns/1ps
module tgl_cfg_regs
    import trace_gate_pkg::*;
#(
    parameter int unsigned N_ADDR     = 16,
    parameter int unsigned N_WP       = 8,
    parameter bit          WP_PRESENT = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [REG_DATA_W-1:0] wdata,
    output logic [REG_DATA_W-1:0] rdata,
    output logic [N_ADDR-1:0]     addr_start_msk,
    output logic [N_ADDR-1:0]     addr_stop_msk,
    output logic [N_WP-1:0]       wp_start_msk,
    output logic [N_WP-1:0]       wp_stop_msk
);
    logic unused_wdata;
    assign unused_wdata = ^wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_start_msk <= '0;
            addr_stop_msk  <= '0;
        end else if (we && addr == ADDR_SEL_REG) begin
            addr_start_msk <= wdata[0 +: N_ADDR];
            addr_stop_msk  <= wdata[FIELD_STEP +: N_ADDR];
        end
    end

    generate
        if (WP_PRESENT) begin : g_wp_regs
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    wp_start_msk <= '0;
                    wp_stop_msk  <= '0;
                end else if (we && addr == WP_SEL_REG) begin
                    wp_start_msk <= wdata[0 +: N_WP];
                    wp_stop_msk  <= wdata[FIELD_STEP +: N_WP];
                end
            end
        end else begin : g_no_wp
            assign wp_start_msk = '0;
            assign wp_stop_msk  = '0;
        end
    endgenerate

    always_comb begin
        rdata = '0;
        unique case (addr)
            ADDR_SEL_REG: begin
                rdata[0 +: N_ADDR]          = addr_start_msk;
                rdata[FIELD_STEP +: N_ADDR] = addr_stop_msk;
            end
            WP_SEL_REG: begin
                rdata[0 +: N_WP]          = wp_start_msk;
                rdata[FIELD_STEP +: N_WP] = wp_stop_msk;
            end
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/tgl_match_sample.sv
`timescale 1ns/1ps
module tgl_match_sample
    import trace_gate_pkg::*;
#(
    parameter int unsigned N_ADDR = 16,
    parameter int unsigned N_WP   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_ADDR-1:0] addr_match,
    input  logic [N_WP-1:0]   wp_match,
    input  logic [N_ADDR-1:0] addr_start_msk,
    input  logic [N_ADDR-1:0] addr_stop_msk,
    input  logic [N_WP-1:0]   wp_start_msk,
    input  logic [N_WP-1:0]   wp_stop_msk,
    output gate_evt_t         evt_q
);
    gate_evt_t evt_d;

    always_comb begin
        evt_d.start = |(addr_match & addr_start_msk) | |(wp_match & wp_start_msk);
        evt_d.stop  = |(addr_match & addr_stop_msk)  | |(wp_match & wp_stop_msk);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= evt_d;
    end
endmodule

// File: rtl/tgl_state_fsm.sv
`timescale 1ns/1ps
module tgl_state_fsm
    import trace_gate_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  gate_evt_t             evt,
    input  logic                  onoff,
    input  logic [RES_CODE_W-1:0] res_sel,
    output logic                  state_on,
    output logic                  trace_en,
    output logic                  res_hit
);
    gate_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: if (evt.start) state_d = ST_ON;
            ST_ON:  if (evt.stop && !evt.start) state_d = ST_OFF;
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_on = (state_q == ST_ON);
        trace_en = state_on && onoff;
        res_hit  = state_on && (res_sel == RES_LATCH_CODE);
    end
endmodule

// File: rtl/trace_gate_latch.sv
`timescale 1ns/1ps
module trace_gate_latch
    import trace_gate_pkg::*;
#(
    parameter int unsigned N_ADDR     = 16,
    parameter int unsigned N_WP       = 8,
    parameter bit          WP_PRESENT = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we_i,
    input  logic [1:0]            cfg_addr_i,
    input  logic [31:0]           cfg_wdata_i,
    output logic [31:0]           cfg_rdata_o,
    input  logic [15:0]           addr_match_i,
    input  logic [7:0]            wp_match_i,
    input  logic                  onoff_i,
    input  logic [6:0]            res_sel_i,
    output logic                  trace_en_o,
    output logic                  res_hit_o
);
    logic [N_ADDR-1:0] addr_start_msk, addr_stop_msk;
    logic [N_WP-1:0]   wp_start_msk, wp_stop_msk;
    gate_evt_t         evt_q;
    logic              start_q, stop_q, trace_on;

    tgl_cfg_regs #(.N_ADDR(N_ADDR), .N_WP(N_WP), .WP_PRESENT(WP_PRESENT)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .we            (cfg_we_i),
        .addr          (cfg_addr_i),
        .wdata         (cfg_wdata_i),
        .rdata         (cfg_rdata_o),
        .addr_start_msk(addr_start_msk),
        .addr_stop_msk (addr_stop_msk),
        .wp_start_msk  (wp_start_msk),
        .wp_stop_msk   (wp_stop_msk)
    );

    tgl_match_sample #(.N_ADDR(N_ADDR), .N_WP(N_WP)) u_sample (
        .clk           (clk),
        .rst_n         (rst_n),
        .addr_match    (addr_match_i[N_ADDR-1:0]),
        .wp_match      (wp_match_i[N_WP-1:0]),
        .addr_start_msk(addr_start_msk),
        .addr_stop_msk (addr_stop_msk),
        .wp_start_msk  (wp_start_msk),
        .wp_stop_msk   (wp_stop_msk),
        .evt_q         (evt_q)
    );

    assign start_q = evt_q.start;
    assign stop_q  = evt_q.stop;

    tgl_state_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt_q),
        .onoff   (onoff_i),
        .res_sel (res_sel_i),
        .state_on(trace_on),
        .trace_en(trace_en_o),
        .res_hit (res_hit_o)
    );
endmodule

// File: rtl/trace_gate_latch_chk.sv
`timescale 1ns/1ps
module trace_gate_latch_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_q,
    input logic        stop_q,
    input logic        trace_on,
    input logic        onoff_i,
    input logic        trace_en_o,
    input logic [1:0]  cfg_addr_i,
    input logic [31:0] cfg_rdata_o
);
    p_reset_off_r1: assert property (@(posedge clk) !rst_n |=> !trace_on);

    p_start_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |=> trace_on);

    p_stop_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_q && !start_q) |=> !trace_on);

    p_idle_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_q && !stop_q) |=> $stable(trace_on));

    p_wp_reserved_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr_i == 2'd1) |-> (cfg_rdata_o[31:24] == 8'h00 && cfg_rdata_o[15:8] == 8'h00));

    p_gate_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !onoff_i |-> !trace_en_o);
endmodule

bind trace_gate_latch trace_gate_latch_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_q    (start_q),
    .stop_q     (stop_q),
    .trace_on   (trace_on),
    .onoff_i    (onoff_i),
    .trace_en_o (trace_en_o),
    .cfg_addr_i (cfg_addr_i),
    .cfg_rdata_o(cfg_rdata_o)
);

// File: tb/trace_gate_latch_tb_top.sv
`timescale 1ns/1ps
module trace_gate_latch_tb_top;
    localparam logic [6:0] CODE = 7'b101_1111;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we_i = 1'b0;
    logic [1:0]  cfg_addr_i = '0;
    logic [31:0] cfg_wdata_i = '0;
    logic [31:0] cfg_rdata_o;
    logic [15:0] addr_match_i = '0;
    logic [7:0]  wp_match_i = '0;
    logic        onoff_i = 1'b1;
    logic [6:0]  res_sel_i = CODE;
    logic        trace_en_o, res_hit_o;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    trace_gate_latch dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
        .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o),
        .addr_match_i(addr_match_i), .wp_match_i(wp_match_i),
        .onoff_i(onoff_i), .res_sel_i(res_sel_i),
        .trace_en_o(trace_en_o), .res_hit_o(res_hit_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr_i = a;
        #1 d = cfg_rdata_o;
    endtask

    // drive one pulse; mid = state after the capture edge, state read at the end
    task automatic pulse(input logic [15:0] am, input logic [7:0] wm, output logic mid);
        @(negedge clk);
        addr_match_i = am; wp_match_i = wm;
        @(negedge clk);
        addr_match_i = '0; wp_match_i = '0;
        mid = res_hit_o;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 trace_en after reset", 32'(trace_en_o), 0);
        check("R1 res_hit after reset", 32'(res_hit_o), 0);
        reg_read(2'd0, d); check("R1 reg0 after reset", d, 0);
        reg_read(2'd1, d); check("R1 reg1 after reset", d, 0);
    endtask

    task automatic t_registers();
        logic [31:0] d;
        reg_write(2'd0, 32'hA5C3_0F1E);
        reg_read(2'd0, d); check("R2 reg0 readback", d, 32'hA5C3_0F1E);
        reg_write(2'd1, 32'hFFFF_FFFF);
        reg_read(2'd1, d); check("R7 reg1 reserved bits zero", d, 32'h00FF_00FF);
        reg_write(2'd2, 32'h1234_5678);
        reg_write(2'd3, 32'hFFFF_FFFF);
        reg_read(2'd2, d); check("R11 unmapped read zero", d, 0);
        reg_read(2'd0, d); check("R11 reg0 untouched", d, 32'hA5C3_0F1E);
        reg_read(2'd1, d); check("R11 reg1 untouched", d, 32'h00FF_00FF);
    endtask

    task automatic t_addr_start_stop();
        logic mid;
        // start lines 0,1 ; stop lines 4,5
        reg_write(2'd0, 32'h0030_0003);
        reg_write(2'd1, 32'h0080_0001);
        pulse(16'h0002, 8'h00, mid);
        check("R12 no change on capture edge (start)", 32'(mid), 0);
        check("R3 start sets", 32'(res_hit_o), 1);
        repeat (5) @(negedge clk);
        check("R3 state holds", 32'(res_hit_o), 1);
        pulse(16'h0100, 8'h00, mid);
        check("R5 unselected line ignored while ON", 32'(res_hit_o), 1);
        pulse(16'h0020, 8'h00, mid);
        check("R12 no change on capture edge (stop)", 32'(mid), 1);
        check("R4 stop clears", 32'(res_hit_o), 0);
        repeat (4) @(negedge clk);
        check("R4 state holds off", 32'(res_hit_o), 0);
        pulse(16'h0004, 8'h00, mid);
        check("R5 unselected line ignored while OFF", 32'(res_hit_o), 0);
    endtask

    task automatic t_conflict();
        logic mid;
        pulse(16'h0011, 8'h00, mid);
        check("R6 start+stop same cycle gives ON", 32'(res_hit_o), 1);
        pulse(16'h0011, 8'h00, mid);
        check("R6 start+stop while ON stays ON", 32'(res_hit_o), 1);
        // line 6 in both masks
        reg_write(2'd0, 32'h0070_0043);
        pulse(16'h0010, 8'h00, mid);
        check("R4 stop before overlap test", 32'(res_hit_o), 0);
        pulse(16'h0040, 8'h00, mid);
        check("R6 line in both masks acts as start", 32'(res_hit_o), 1);
    endtask

    task automatic t_watchpoint();
        logic mid;
        pulse(16'h0000, 8'h80, mid);
        check("R8 watchpoint stop", 32'(res_hit_o), 0);
        pulse(16'h0000, 8'h08, mid);
        check("R5 unselected watchpoint ignored", 32'(res_hit_o), 0);
        pulse(16'h0000, 8'h01, mid);
        check("R8 watchpoint start", 32'(res_hit_o), 1);
    endtask

    task automatic t_outputs();
        logic mid;
        @(negedge clk);
        onoff_i = 1'b1;
        #1 check("R9 trace_en follows state", 32'(trace_en_o), 1);
        onoff_i = 1'b0;
        #1 check("R9 trace_en gated off", 32'(trace_en_o), 0);
        check("R10 resource independent of onoff", 32'(res_hit_o), 1);
        res_sel_i = 7'b101_1110;
        #1 check("R10 other code gives 0", 32'(res_hit_o), 0);
        res_sel_i = CODE;
        pulse(16'h0000, 8'h80, mid);
        check("R10 resource tracks stop with onoff low", 32'(res_hit_o), 0);
        pulse(16'h0001, 8'h00, mid);
        check("R10 resource tracks start with onoff low", 32'(res_hit_o), 1);
        check("R9 trace_en still gated", 32'(trace_en_o), 0);
        onoff_i = 1'b1;
        #1 check("R9 trace_en on when enabled", 32'(trace_en_o), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_registers();
        t_addr_start_stop();
        t_conflict();
        t_watchpoint();
        t_outputs();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(10 * 200000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule